// File: doc/BRIEF.md
# Speed-Negotiation Exchange Parser

This block watches, without driving anything, the byte stream of a smart-card link after the answer to reset. It follows one speed-negotiation exchange: a request sent by the reader and then a response sent by the card. Each message has the same shape. It opens with the start code 0xFF and a format byte. Up to three optional parameter bytes follow, and a check byte closes the message. The block stores both messages and flags a bad check byte on either one. It takes the new clock-rate and divisor indices from the card's reply. At the end it pulses a load strobe so that a session tracker can program the new bit-rate ratio.

One sequencer serves both messages. A direction bit in the state selects request or response, and the three low bits count through the byte positions. Received bytes come in as a valid strobe with a data byte. An abort input, driven by the session's waiting-time timeout, drops an exchange that is partly done.

Top module: `spdneg_parser`

## Requirements
- R1: While `rst` is high and after it is released, both captured images read zero, both check flags are 0, `ratio_load` is 0, and the indices hold their reset values (`clk_idx` = `RST_CLK_IDX`, `div_idx` = `RST_DIV_IDX`, both 1 by default).
- R2: While waiting for a request, an offered byte other than 0xFF is ignored: no image, flag or index changes, and the parser keeps waiting for a request.
- R3: Within a message, format bit 4 enables parameter byte 1, bit 5 enables parameter byte 2 and bit 6 enables parameter byte 3. Absent bytes are skipped in that order, and the other format bits have no effect. In the 48-bit images, slot k occupies bits [8k+7:8k], with slot 0 = start, 1 = format, 2..4 = parameters 1..3 and 5 = check.
- R4: The check byte always ends a message. After the request's check byte, the next accepted byte, whatever its value, is stored as the response's start byte.
- R5: The response is captured into `rsp_img` with the same slot layout. The request image is not disturbed while the response is captured.
- R6: In the cycle after the response's check byte is accepted, `ratio_load` is high for exactly one cycle. If the response carried parameter byte 1, `clk_idx` and `div_idx` change in that same cycle to its upper and lower nibble. The parser then waits for a new request.
- R7: If the response omits parameter byte 1, `clk_idx` and `div_idx` keep their previous values, while `ratio_load` still pulses.
- R8: A high `sess_abort` returns the parser to waiting for a request. It does not pulse `ratio_load`, does not change the indices, and leaves both images unchanged. A byte offered in the same cycle as the abort is discarded.
- R9: When a message's check byte is accepted, its flag (`req_chk_err` or `rsp_chk_err`) becomes 1 if the XOR of all that message's bytes, from the start byte through the check byte, is nonzero, and 0 otherwise. The flag is held until that direction's next check byte.
- R10: Accepting a message's start byte clears that direction's image before storing the start byte, so the slots of absent bytes read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A received byte is offered this cycle |
| byte_in | input | 8 | Received byte |
| sess_abort | input | 1 | Session timeout; abandons a partial exchange |
| req_img | output | 48 | Captured request, six byte slots |
| rsp_img | output | 48 | Captured response, six byte slots |
| clk_idx | output | 4 | Negotiated clock-rate index |
| div_idx | output | 4 | Negotiated divisor index |
| ratio_load | output | 1 | One-cycle strobe: apply the new ratio |
| req_chk_err | output | 1 | Request check byte mismatch |
| rsp_chk_err | output | 1 | Response check byte mismatch |

## Verification
A wrong sequencer state shows up at the ports within one accepted byte. Either a byte lands in the wrong slot or direction of an image, or `ratio_load` fires one message early or late, so the bench compares both whole images after every exchange. A stale pending parameter or a wrong index latch shows up only in the cycle of the load strobe. The bench therefore also aims at responses that drop parameter byte 1, and at aborts that arrive after that byte was seen. A bad parity accumulator is visible one cycle after each check byte, through the two flags.

// File: rtl/spdneg_pkg.sv
package spdneg_pkg;
    localparam int unsigned BW    = 8;
    localparam int unsigned NSLOT = 6;
    localparam int unsigned IDXW  = BW / 2;
    localparam logic [BW-1:0] START_CODE = 8'hFF;

    typedef enum logic [2:0] {
        SUB_START = 3'd0,
        SUB_FMT   = 3'd1,
        SUB_P1    = 3'd2,
        SUB_P2    = 3'd3,
        SUB_P3    = 3'd4,
        SUB_CHK   = 3'd5
    } sub_e;

    // bit 4 = response direction, bit 3 unused, bits 2:0 = position
    typedef struct packed {
        logic rsp;
        logic rsvd;
        sub_e sub;
    } pstate_t;

    function automatic sub_e next_sub(input sub_e cur, input logic [BW-1:0] fmt);
        sub_e n;
        case (cur)
            SUB_START: n = SUB_FMT;
            SUB_FMT:   n = fmt[4] ? SUB_P1 : fmt[5] ? SUB_P2 : fmt[6] ? SUB_P3 : SUB_CHK;
            SUB_P1:    n = fmt[5] ? SUB_P2 : fmt[6] ? SUB_P3 : SUB_CHK;
            SUB_P2:    n = fmt[6] ? SUB_P3 : SUB_CHK;
            default:   n = SUB_CHK;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/spdneg_seq.sv
module spdneg_seq
    import spdneg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_vld,
    input  logic [BW-1:0] byte_in,
    input  logic          sess_abort,
    output pstate_t       cur,
    output logic          acc
);
    pstate_t       nxt;
    logic [BW-1:0] fmt_q;
    logic [BW-1:0] fmt_sel;
    logic          idle_gate;

    assign idle_gate = !cur.rsp && (cur.sub == SUB_START) && (byte_in != START_CODE);
    assign acc       = byte_vld && !sess_abort && !idle_gate;
    assign fmt_sel   = (cur.sub == SUB_FMT) ? byte_in : fmt_q;

    always_comb begin
        nxt = cur;
        if (sess_abort) begin
            nxt.rsp = 1'b0;
            nxt.sub = SUB_START;
        end else if (acc) begin
            if (cur.sub == SUB_CHK) begin
                nxt.rsp = ~cur.rsp;
                nxt.sub = SUB_START;
            end else begin
                nxt.sub = next_sub(cur.sub, fmt_sel);
            end
        end
        nxt.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '{rsp: 1'b0, rsvd: 1'b0, sub: SUB_START};
            fmt_q <= '0;
        end else begin
            cur <= nxt;
            if (acc && cur.sub == SUB_FMT)
                fmt_q <= byte_in;
        end
    end

    // R3
    sub_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cur.sub <= SUB_CHK);
    // R4
    req_to_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !cur.rsp && cur.sub == SUB_CHK) |=> (cur.rsp && cur.sub == SUB_START));
    // R8
    abort_home_chk: assert property (@(posedge clk) disable iff (rst)
        sess_abort |=> (!cur.rsp && cur.sub == SUB_START));
    // R2
    idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !cur.rsp && cur.sub == SUB_START && byte_in != START_CODE)
            |=> (!cur.rsp && cur.sub == SUB_START));
endmodule

// File: rtl/spdneg_msgcap.sv
module spdneg_msgcap
    import spdneg_pkg::*;
#(
    parameter bit IS_RSP = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc,
    input  pstate_t             cur,
    input  logic [BW-1:0]       byte_in,
    output logic [NSLOT*BW-1:0] img,
    output logic                err
);
    logic [NSLOT-1:0][BW-1:0] slot_q;
    logic [BW-1:0]            par_q;
    logic                     mine;

    assign mine = acc && (cur.rsp == IS_RSP);
    assign img  = slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            par_q  <= '0;
            err    <= 1'b0;
        end else if (mine) begin
            if (cur.sub == SUB_START) begin
                slot_q    <= '0;
                slot_q[0] <= byte_in;
                par_q     <= byte_in;
            end else begin
                slot_q[cur.sub] <= byte_in;
                par_q           <= par_q ^ byte_in;
                if (cur.sub == SUB_CHK)
                    err <= (par_q ^ byte_in) != '0;
            end
        end
    end

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (mine && cur.sub == SUB_START) |=> (slot_q[NSLOT-1:1] == '0));
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(mine && cur.sub == SUB_CHK) |=> $stable(err));
endmodule

// File: rtl/spdneg_rate.sv
module spdneg_rate
    import spdneg_pkg::*;
#(
    parameter logic [IDXW-1:0] RST_CLK_IDX = 4'd1,
    parameter logic [IDXW-1:0] RST_DIV_IDX = 4'd1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc,
    input  pstate_t         cur,
    input  logic [BW-1:0]   byte_in,
    output logic            ratio_load,
    output logic [IDXW-1:0] clk_idx,
    output logic [IDXW-1:0] div_idx
);
    logic [BW-1:0] pend_q;
    logic          pend_vld_q;
    logic          take;

    assign take = acc && cur.rsp;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            ratio_load <= 1'b0;
            clk_idx    <= RST_CLK_IDX;
            div_idx    <= RST_DIV_IDX;
        end else begin
            ratio_load <= 1'b0;
            if (take) begin
                case (cur.sub)
                    SUB_START: pend_vld_q <= 1'b0;
                    SUB_P1: begin
                        pend_q     <= byte_in;
                        pend_vld_q <= 1'b1;
                    end
                    SUB_CHK: begin
                        ratio_load <= 1'b1;
                        pend_vld_q <= 1'b0;
                        if (pend_vld_q) begin
                            clk_idx <= pend_q[BW-1:IDXW];
                            div_idx <= pend_q[IDXW-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6
    load_single_chk: assert property (@(posedge clk) disable iff (rst)
        ratio_load |=> !ratio_load);
    // R7
    idx_only_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({clk_idx, div_idx}) |-> ratio_load);
endmodule

// File: rtl/spdneg_parser.sv
module spdneg_parser
    import spdneg_pkg::*;
#(
    parameter logic [IDXW-1:0] RST_CLK_IDX = 4'd1,
    parameter logic [IDXW-1:0] RST_DIV_IDX = 4'd1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                byte_vld,
    input  logic [BW-1:0]       byte_in,
    input  logic                sess_abort,
    output logic [NSLOT*BW-1:0] req_img,
    output logic [NSLOT*BW-1:0] rsp_img,
    output logic [IDXW-1:0]     clk_idx,
    output logic [IDXW-1:0]     div_idx,
    output logic                ratio_load,
    output logic                req_chk_err,
    output logic                rsp_chk_err
);
    localparam int unsigned NDIR = 2;

    pstate_t              cur;
    logic                 acc;
    logic [NSLOT*BW-1:0]  img_w [NDIR];
    logic                 err_w [NDIR];

    spdneg_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .sess_abort (sess_abort),
        .cur        (cur),
        .acc        (acc)
    );

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        spdneg_msgcap #(.IS_RSP(g == 1)) u_cap (
            .clk     (clk),
            .rst     (rst),
            .acc     (acc),
            .cur     (cur),
            .byte_in (byte_in),
            .img     (img_w[g]),
            .err     (err_w[g])
        );
    end

    spdneg_rate #(
        .RST_CLK_IDX (RST_CLK_IDX),
        .RST_DIV_IDX (RST_DIV_IDX)
    ) u_rate (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .cur        (cur),
        .byte_in    (byte_in),
        .ratio_load (ratio_load),
        .clk_idx    (clk_idx),
        .div_idx    (div_idx)
    );

    assign req_img     = img_w[0];
    assign rsp_img     = img_w[1];
    assign req_chk_err = err_w[0];
    assign rsp_chk_err = err_w[1];

    // R8
    abort_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        sess_abort |=> !ratio_load);
    // R5
    req_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cur.rsp) |=> $stable(req_img));
endmodule

// File: tb/test_spdneg_parser.sv
module test_spdneg_parser;
    logic        clk = 1'b0;
    logic        rst;
    logic        byte_vld;
    logic [7:0]  byte_in;
    logic        sess_abort;
    logic [47:0] req_img, rsp_img;
    logic [3:0]  clk_idx, div_idx;
    logic        ratio_load, req_chk_err, rsp_chk_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    logic [47:0] exp_req, exp_rsp;
    logic [3:0]  exp_ci, exp_di;
    logic        exp_qe, exp_se;

    always #5 clk = ~clk;

    spdneg_parser i_spdneg_parser (
        .clk, .rst, .byte_vld, .byte_in, .sess_abort,
        .req_img, .rsp_img, .clk_idx, .div_idx,
        .ratio_load, .req_chk_err, .rsp_chk_err
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] b, input bit v, input bit ab);
        @(negedge clk);
        byte_vld   = v;
        byte_in    = b;
        sess_abort = ab;
        @(negedge clk);
        byte_vld   = 1'b0;
        sess_abort = 1'b0;
    endtask

    function automatic logic [47:0] img_of(input logic [7:0] st, input logic [7:0] fmt,
                                           input logic [7:0] a, input logic [7:0] b,
                                           input logic [7:0] c, input logic [7:0] k);
        return {k, fmt[6] ? c : 8'h00, fmt[5] ? b : 8'h00, fmt[4] ? a : 8'h00, fmt, st};
    endfunction

    function automatic logic [7:0] xor_of(input logic [7:0] st, input logic [7:0] fmt,
                                          input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] c);
        return st ^ fmt ^ (fmt[4] ? a : 8'h00) ^ (fmt[5] ? b : 8'h00) ^ (fmt[6] ? c : 8'h00);
    endfunction

    // Sends one message; returns the image expected for it
    task automatic send_msg(input logic [7:0] st, input logic [7:0] fmt, input logic [7:0] a,
                            input logic [7:0] b, input logic [7:0] c, input bit bad,
                            input bit is_rsp, output logic [47:0] img, output logic err);
        logic [7:0] k;
        k   = xor_of(st, fmt, a, b, c) ^ (bad ? 8'h5A : 8'h00);
        img = img_of(st, fmt, a, b, c, k);
        err = bad;
        drive(st, 1, 0);
        check(ratio_load == 0, "R6 no load mid-message", 64'(ratio_load), 0);
        drive(fmt, 1, 0);
        if (fmt[4]) drive(a, 1, 0);
        if (fmt[5]) drive(b, 1, 0);
        if (fmt[6]) drive(c, 1, 0);
        if (!is_rsp) begin
            drive(k, 1, 0);
            check(ratio_load == 0, "R4 no load after request", 64'(ratio_load), 0);
        end else begin
            drive(k, 1, 0);
        end
    endtask

    task automatic exchange(input logic [7:0] qfmt, input logic [7:0] sfmt,
                            input logic [7:0] sp1, input bit qbad, input bit sbad, input logic [7:0] sst);
        logic [7:0] r1, r2, r3, r4, r5, r6;
        r1 = 8'($urandom); r2 = 8'($urandom); r3 = 8'($urandom);
        r4 = 8'($urandom); r5 = 8'($urandom); r6 = 8'($urandom);
        send_msg(8'hFF, qfmt, r1, r2, r3, qbad, 0, exp_req, exp_qe);
        check(req_img == exp_req, "R3 R10 request image", 64'(req_img), 64'(exp_req));
        check(req_chk_err == exp_qe, "R9 request flag", 64'(req_chk_err), 64'(exp_qe));
        send_msg(sst, sfmt, sp1, r5, r6, sbad, 1, exp_rsp, exp_se);
        if (sfmt[4]) begin
            exp_ci = sp1[7:4];
            exp_di = sp1[3:0];
        end
        check(ratio_load == 1, "R6 load strobe", 64'(ratio_load), 1);
        check(rsp_img == exp_rsp, "R4 R5 response image", 64'(rsp_img), 64'(exp_rsp));
        check(req_img == exp_req, "R5 request kept", 64'(req_img), 64'(exp_req));
        check(rsp_chk_err == exp_se, "R9 response flag", 64'(rsp_chk_err), 64'(exp_se));
        check(req_chk_err == exp_qe, "R9 request flag held", 64'(req_chk_err), 64'(exp_qe));
        check({clk_idx, div_idx} == {exp_ci, exp_di}, "R6 R7 indices",
              64'({clk_idx, div_idx}), 64'({exp_ci, exp_di}));
        @(negedge clk);
        check(ratio_load == 0, "R6 strobe one cycle", 64'(ratio_load), 0);
        r4 = r4;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; byte_vld = 0; byte_in = 0; sess_abort = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        exp_req = '0; exp_rsp = '0; exp_ci = 4'd1; exp_di = 4'd1; exp_qe = 0; exp_se = 0;
        // R1 reset state
        check(req_img == 0 && rsp_img == 0, "R1 images zero", 64'(req_img), 0);
        check({clk_idx, div_idx} == 8'h11, "R1 reset indices", 64'({clk_idx, div_idx}), 64'h11);
        check(!ratio_load && !req_chk_err && !rsp_chk_err, "R1 strobe and flags",
              64'({ratio_load, req_chk_err, rsp_chk_err}), 0);

        // R6 plain negotiation with parameter 1 in both messages
        exchange(8'h10, 8'h10, 8'h96, 0, 0, 8'hFF);
        // R3 all parameter bytes present, low format bits set
        exchange(8'h7F, 8'hF3, 8'h18, 0, 0, 8'hFF);

        // R2 junk while idle leaves everything unchanged
        drive(8'h3B, 1, 0);
        check(req_img == exp_req, "R2 junk ignored", 64'(req_img), 64'(exp_req));
        drive(8'h00, 1, 0);
        check(rsp_img == exp_rsp && ratio_load == 0, "R2 junk no effect", 64'(rsp_img), 64'(exp_rsp));

        // R7 response without parameter 1
        exchange(8'h10, 8'h60, 8'h95, 0, 0, 8'hFF);
        // R4 response start byte of another value is still captured
        exchange(8'h00, 8'h00, 8'h00, 0, 0, 8'h3C);
        // R9 corrupted checks
        exchange(8'h20, 8'h10, 8'h13, 1, 0, 8'hFF);
        exchange(8'h40, 8'h30, 8'h94, 0, 1, 8'hFF);

        // R8 abort during response after parameter 1
        drive(8'hFF, 1, 0); drive(8'h10, 1, 0); drive(8'h25, 1, 0); drive(8'hDA, 1, 0);
        exp_req = img_of(8'hFF, 8'h10, 8'h25, 0, 0, 8'hDA);
        drive(8'hFF, 1, 0); drive(8'h10, 1, 0); drive(8'h47, 1, 0);
        exp_rsp = img_of(8'hFF, 8'h10, 8'h47, 0, 0, 0);
        drive(8'h00, 0, 1);
        check(ratio_load == 0, "R8 no load on abort", 64'(ratio_load), 0);
        check({clk_idx, div_idx} == {exp_ci, exp_di}, "R8 indices kept",
              64'({clk_idx, div_idx}), 64'({exp_ci, exp_di}));
        drive(8'hB8, 1, 0);
        check(rsp_img == exp_rsp && req_img == exp_req, "R8 back to request wait",
              64'(rsp_img), 64'(exp_rsp));
        // R8 byte with abort in the same cycle is dropped
        drive(8'hFF, 1, 1);
        check(req_img == exp_req, "R8 simultaneous byte dropped", 64'(req_img), 64'(exp_req));
        exchange(8'h10, 8'h10, 8'h11, 0, 0, 8'hFF);

        // random mix
        for (int i = 0; i < 60; i++) begin
            exchange(8'($urandom), 8'($urandom), 8'($urandom),
                     ($urandom % 4) == 0, ($urandom % 4) == 0, 8'hFF);
        end

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule